// File: doc/BRIEF.md
# Eight-bit universal shift and storage register with shared parallel bus

The block is an eight-bit register that on every rising clock edge either keeps its contents, moves them one place toward the most significant bit, moves them one place toward the least significant bit, or takes a new word from its parallel port. A two-bit mode input picks the operation. Two serial inputs supply the bit that enters at the open end during a shift. A synchronous active-low reset clears the word on a clock edge and outranks every mode.

The parallel port is meant to sit on one set of bidirectional pads. The block presents it as a split pair: `par_in` carries the pad values into the register for loads, and `par_out` carries the register contents, with `par_drive` saying when the pad buffers may drive. At chip level each pad is `pad = par_drive ? par_out : 'z` with `par_in` tied to the pad. The buffers drive only while both active-low enables are low and the load mode is not selected, so a load never fights its own outputs. The lowest and highest bits are also given on `q_lo` and `q_hi`, which are always driven so that several registers can be chained into a wider shifter: `q_hi` of one feeds `fill_lo` of the next, and `q_lo` of the next feeds `fill_hi` of the previous.

Top module: `ushreg8`

## Requirements
- R1: The reset input `rst_n` acts only at a rising clock edge: while it is low between edges the contents are unchanged, and after an edge with `rst_n` low all bits are 0.
- R2: With `mode` = 2'b00 (hold) the contents stay the same across an edge, whatever `par_in`, `fill_lo` and `fill_hi` do.
- R3: With `mode` = 2'b01 (shift up) each bit i takes the old bit i-1 and bit 0 takes `fill_lo`.
- R4: With `mode` = 2'b10 (shift down) each bit i takes the old bit i+1 and bit 7 takes `fill_hi`.
- R5: With `mode` = 2'b11 (load) the contents become the value on `par_in`.
- R6: Reset takes priority over every mode, load included: `rst_n` low with `mode` = 2'b11 still gives all zeros.
- R7: `par_drive` is high only when `oe_a_n` and `oe_b_n` are both low and `mode` is not 2'b11; in every other case it is low.
- R8: `par_out` equals the register contents, so while `par_drive` is high the pads show the stored word.
- R9: `q_lo` equals bit 0 and `q_hi` equals bit 7 at all times, for every value of the enables.
- R10: Two instances chained through `q_hi`→`fill_lo` and `q_lo`→`fill_hi` behave as one sixteen-bit register in both shift directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| fill_lo | input | 1 | Serial bit entering bit 0 on a shift up |
| fill_hi | input | 1 | Serial bit entering bit 7 on a shift down |
| oe_a_n | input | 1 | First output enable, active low |
| oe_b_n | input | 1 | Second output enable, active low |
| par_in | input | 8 | Parallel load data from the pads |
| par_out | output | 8 | Register contents toward the pad drivers |
| par_drive | output | 1 | Pad driver enable; pads are high impedance when low |
| q_lo | output | 1 | Continuous copy of bit 0 for chaining |
| q_hi | output | 1 | Continuous copy of bit 7 for chaining |

## Verification
Two instances are chained into a sixteen-bit shifter and driven with irregular serial streams in both directions against a model in the bench, which separates a wrong fill end, a broken link between the halves and a shift in the wrong direction. Loads of all-zero, all-one and alternating words show stuck or swapped bits, and hold cycles with toggling data and serial inputs show any leak into the stored word. Reset is raised in the middle of a cycle and together with a load, telling a synchronous, dominant clear from an immediate or a lower-priority one. Every combination of the two enables with every mode is applied to show the pads float unless both enables are low outside load mode, while the chaining outputs keep following the end bits.

// File: rtl/ushreg_pkg.sv
package ushreg_pkg;

  typedef enum logic [1:0] {
    SH_HOLD = 2'b00,
    SH_UP   = 2'b01,
    SH_DOWN = 2'b10,
    SH_LOAD = 2'b11
  } shmode_e;

  // Pad drivers may turn on only when both enables are asserted (low)
  // and the bus is not needed as a load source.
  function automatic logic pads_may_drive(input logic oe_a_n,
                                          input logic oe_b_n,
                                          input shmode_e md);
    return (!oe_a_n) && (!oe_b_n) && (md != SH_LOAD);
  endfunction

endpackage

// File: rtl/ushreg_next.sv
module ushreg_next #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]    cur,
  input  ushreg_pkg::shmode_e md,
  input  logic                fill_lo,
  input  logic                fill_hi,
  input  logic [WIDTH-1:0]    load_val,
  output logic [WIDTH-1:0]    nxt
);
  import ushreg_pkg::*;

  localparam int TOP = WIDTH - 1;

  // Bit i takes bit i-1; the freed bit 0 takes the serial fill.
  function automatic logic [WIDTH-1:0] move_up(input logic [WIDTH-1:0] v,
                                               input logic fill);
    logic [WIDTH-1:0] r;
    r[0] = fill;
    for (int i = 1; i < WIDTH; i++) r[i] = v[i-1];
    return r;
  endfunction

  // Bit i takes bit i+1; the freed top bit takes the serial fill.
  function automatic logic [WIDTH-1:0] move_down(input logic [WIDTH-1:0] v,
                                                 input logic fill);
    logic [WIDTH-1:0] r;
    r[TOP] = fill;
    for (int i = 0; i < TOP; i++) r[i] = v[i+1];
    return r;
  endfunction

  always_comb begin
    unique case (md)
      SH_UP:   nxt = move_up(cur, fill_lo);
      SH_DOWN: nxt = move_down(cur, fill_hi);
      SH_LOAD: nxt = load_val;
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/ushreg_oectl.sv
module ushreg_oectl (
  input  logic                oe_a_n,
  input  logic                oe_b_n,
  input  ushreg_pkg::shmode_e md,
  output logic                drive
);
  import ushreg_pkg::*;

  assign drive = pads_may_drive(oe_a_n, oe_b_n, md);

endmodule

// File: rtl/ushreg8.sv
module ushreg8 #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             fill_lo,
  input  logic             fill_hi,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] par_out,
  output logic             par_drive,
  output logic             q_lo,
  output logic             q_hi
);
  import ushreg_pkg::*;

  localparam int TOP = WIDTH - 1;

  shmode_e          md;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_nxt;
  logic             clear_evt;   // a clear is taken at this edge
  logic             load_evt;    // a load would be taken at this edge

  assign md        = shmode_e'(mode);
  assign clear_evt = !rst_n;
  assign load_evt  = rst_n && (md == SH_LOAD);

  ushreg_next #(.WIDTH(WIDTH)) u_next (
    .cur      (state_q),
    .md       (md),
    .fill_lo  (fill_lo),
    .fill_hi  (fill_hi),
    .load_val (par_in),
    .nxt      (state_nxt)
  );

  ushreg_oectl u_oectl (
    .oe_a_n (oe_a_n),
    .oe_b_n (oe_b_n),
    .md     (md),
    .drive  (par_drive)
  );

  // Synchronous clear outranks every mode.
  always_ff @(posedge clk) begin
    if (clear_evt) state_q <= '0;
    else           state_q <= state_nxt;
  end

  assign par_out = state_q;
  assign q_lo    = state_q[0];
  assign q_hi    = state_q[TOP];

endmodule

// File: rtl/ushreg8_chk.sv
module ushreg8_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             fill_lo,
  input logic             fill_hi,
  input logic             oe_a_n,
  input logic             oe_b_n,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] state_q,
  input logic [WIDTH-1:0] par_out,
  input logic             par_drive,
  input logic             q_lo,
  input logic             q_hi,
  input logic             load_evt
);
  localparam int TOP = WIDTH - 1;

  logic clr_seen_q;
  logic clr_load_seen_q;

  always_ff @(posedge clk) begin
    clr_seen_q      <= !rst_n;
    clr_load_seen_q <= !rst_n && (mode == 2'b11);
  end

  // R1: an edge with reset low leaves all bits zero
  always @(negedge clk)
    if (clr_seen_q)
      a_r1_sync_clear: assert (state_q == '0);

  // R6: reset wins over a simultaneous load request
  always @(negedge clk)
    if (clr_load_seen_q)
      a_r6_reset_over_load: assert (state_q == '0);

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> $stable(state_q));

  a_r3_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> (state_q[0] == $past(fill_lo)) &&
                        (state_q[TOP:1] == $past(state_q[TOP-1:0])));

  a_r4_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> (state_q[TOP] == $past(fill_hi)) &&
                        (state_q[TOP-1:0] == $past(state_q[TOP:1])));

  a_r5_load_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (state_q == $past(par_in)));

  a_r7_float_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> !par_drive);

  a_r7_float_unless_both: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a_n || oe_b_n) |-> !par_drive);

  a_r8_bus_shows_word: assert property (@(posedge clk) disable iff (!rst_n)
    par_drive |-> (par_out == state_q));

  a_r9_end_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (q_lo == par_out[0]) && (q_hi == par_out[TOP]));

endmodule

bind ushreg8 ushreg8_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .fill_lo   (fill_lo),
  .fill_hi   (fill_hi),
  .oe_a_n    (oe_a_n),
  .oe_b_n    (oe_b_n),
  .par_in    (par_in),
  .state_q   (state_q),
  .par_out   (par_out),
  .par_drive (par_drive),
  .q_lo      (q_lo),
  .q_hi      (q_hi),
  .load_evt  (load_evt)
);

// File: tb/tb_ushreg8.sv
module tb_ushreg8;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       ext_lo, ext_hi;
  logic       oe_a_n, oe_b_n;
  logic [7:0] lo_in, hi_in;
  logic [7:0] lo_out, hi_out;
  logic       lo_drv, hi_drv;
  logic       lo_q0, lo_q7, hi_q0, hi_q7;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Low half: bits 0..7 of the chain; high half: bits 8..15.
  ushreg8 dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .fill_lo(ext_lo), .fill_hi(hi_q0),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .par_in(lo_in), .par_out(lo_out), .par_drive(lo_drv),
    .q_lo(lo_q0), .q_hi(lo_q7)
  );

  ushreg8 dut_hi (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .fill_lo(lo_q7), .fill_hi(ext_hi),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .par_in(hi_in), .par_out(hi_out), .par_drive(hi_drv),
    .q_lo(hi_q0), .q_hi(hi_q7)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One rising edge, then return at the falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] word16();
    return {hi_out, lo_out};
  endfunction

  task automatic load16(input logic [15:0] v);
    mode  = 2'b11;
    lo_in = v[7:0];
    hi_in = v[15:8];
    step();
    mode  = 2'b00;
  endtask

  task automatic t_reset_sync();
    load16(16'hA53C);
    rst_n = 1'b0;
    #1;
    chk("R1 no clear before edge", word16(), 16'hA53C);
    step();
    chk("R1 clear at edge", word16(), 16'h0000);
    rst_n = 1'b1;
  endtask

  task automatic t_hold();
    load16(16'h5A96);
    mode = 2'b00;
    for (int k = 0; k < 4; k++) begin
      lo_in  = 8'(k * 37);
      hi_in  = ~8'(k * 37);
      ext_lo = k[0];
      ext_hi = ~k[0];
      step();
      chk("R2 hold keeps word", word16(), 16'h5A96);
    end
  endtask

  task automatic t_shift_up();
    logic [15:0] ref16 = 16'h8137;
    logic [7:0]  lfsr  = 8'hB5;
    load16(ref16);
    mode = 2'b01;
    for (int k = 0; k < 20; k++) begin
      ext_lo = lfsr[0];
      ext_hi = ~lfsr[0];
      ref16  = {ref16[14:0], lfsr[0]};
      lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step();
      chk("R3 R10 shift up chain", word16(), ref16);
    end
    mode = 2'b00;
  endtask

  task automatic t_shift_down();
    logic [15:0] ref16 = 16'h1EC9;
    logic [7:0]  lfsr  = 8'h4D;
    load16(ref16);
    mode = 2'b10;
    for (int k = 0; k < 20; k++) begin
      ext_hi = lfsr[0];
      ext_lo = ~lfsr[0];
      ref16  = {lfsr[0], ref16[15:1]};
      lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step();
      chk("R4 R10 shift down chain", word16(), ref16);
    end
    mode = 2'b00;
  endtask

  task automatic t_load();
    logic [15:0] pats [4] = '{16'h0000, 16'hFFFF, 16'h55AA, 16'hC3E1};
    foreach (pats[i]) begin
      load16(pats[i]);
      chk("R5 parallel load", word16(), pats[i]);
    end
  endtask

  task automatic t_reset_over_load();
    load16(16'h7EE7);
    rst_n = 1'b0;
    mode  = 2'b11;
    lo_in = 8'hFF;
    hi_in = 8'hFF;
    step();
    chk("R6 reset beats load", word16(), 16'h0000);
    rst_n = 1'b1;
    mode  = 2'b00;
  endtask

  task automatic t_drive();
    load16(16'hB24D);
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 4; e++) begin
        mode   = 2'(m);
        oe_a_n = e[0];
        oe_b_n = e[1];
        #1;
        chk("R7 pad drive low half", 32'(lo_drv), 32'((e == 0) && (m != 3)));
        chk("R7 pad drive high half", 32'(hi_drv), 32'((e == 0) && (m != 3)));
      end
    end
    mode   = 2'b00;
    oe_a_n = 1'b0;
    oe_b_n = 1'b0;
    #1;
    chk("R8 driven bus shows word", {15'd0, lo_drv & hi_drv, word16()}, {15'd0, 1'b1, 16'hB24D});
  endtask

  task automatic t_end_bits();
    logic [15:0] pats [3] = '{16'h8001, 16'h7E7E, 16'h0180};
    foreach (pats[i]) begin
      load16(pats[i]);
      for (int e = 1; e < 4; e++) begin
        oe_a_n = e[0];
        oe_b_n = e[1];
        #1;
        chk("R9 chain pins with pads off",
            {28'd0, hi_q7, hi_q0, lo_q7, lo_q0},
            {28'd0, pats[i][15], pats[i][8], pats[i][7], pats[i][0]});
      end
      oe_a_n = 1'b0;
      oe_b_n = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; mode = 2'b00; ext_lo = 1'b0; ext_hi = 1'b0;
    oe_a_n = 1'b0; oe_b_n = 1'b0; lo_in = 8'h00; hi_in = 8'h00;
    @(negedge clk);
    step();
    chk("R1 reset state", word16(), 16'h0000);
    rst_n = 1'b1;
    t_reset_sync();
    t_hold();
    t_shift_up();
    t_shift_down();
    t_load();
    t_reset_over_load();
    t_drive();
    t_end_bits();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule